// File: doc/BRIEF.md
# Two-Thread Shared Execution Unit Arbiter

This block guards a single non-pipelined, multi-cycle execution resource (for example an iterative divider) that two hardware threads share. Each thread raises a request bit when it wants to issue an operation to the resource. When the resource is idle, the block grants it to one requester in the same cycle and starts a countdown. While the countdown runs, the resource is reported busy and every request is refused.

A refused thread sees its stall output asserted, so that it can hold its issue stage. When both threads ask in the same idle cycle, a round-robin pointer picks the thread that was not served most recently, so that neither thread can be locked out. When an operation finishes, a one-cycle completion pulse carries the identity of the thread that owned it. The arithmetic itself lives outside this block. Only the occupancy and the grant timing are modelled here.

Top module: `shared_unit_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, grant_o and done_o are all zero.
- R2: When the unit is idle and exactly one thread requests, that thread's grant bit rises in the same cycle and its stall bit stays low.
- R3: While busy_o is high, no grant is given and every requesting thread sees its stall bit high.
- R4: After a grant in cycle t, busy_o is high in cycles t+1 to t+LATENCY and low in cycle t+LATENCY+1, which is the earliest cycle in which another grant can be given.
- R5: At most one bit of grant_o is high in any cycle.
- R6: When both threads request in an idle cycle, the grant goes to the thread not served by the previous grant. After reset, thread 0 wins the first such tie.
- R7: stall_o[k] is high exactly when thread k requests and is not granted. In a tie, the losing thread stalls.
- R8: done_o is high for one cycle, in cycle t+LATENCY after a grant in cycle t. In that cycle done_tid_o equals the granted thread (0 for bit 0, 1 for bit 1).
- R9: Under continuous requests from both threads, successive grants alternate between the threads.
- R10: With no request, no grant is given and the unit stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 2 | Per-thread request valid, bit k for thread k |
| grant_o | output | 2 | Per-thread grant, same cycle as request |
| stall_o | output | 2 | Per-thread stall for refused requests |
| busy_o | output | 1 | Unit occupied by an operation |
| done_o | output | 1 | One-cycle completion pulse |
| done_tid_o | output | 1 | Thread that owned the completing operation |

## Verification
The bench builds the block with LATENCY set to 3. This keeps each operation four cycles long, so one table can cover a whole run of busy windows, ties, lone requests and completions. The short window allows many consecutive grants within a short run. As a result, alternation under constant contention and the exact grant-to-grant spacing can both be checked over many rounds. A reset applied in the middle of an operation also shows the pointer returning to its initial value.

// File: rtl/sua_pkg.sv
// Package: shared types for the shared-unit arbiter.
// Assumes exactly two contending threads; a thread id is one bit.
package sua_pkg;
    localparam int NUM_THR = 2;
    typedef logic tid_t;
endpackage

// File: rtl/sua_rr_pick.sv
// Round-robin grant selection for two threads.
// Grants only when the unit is idle. On a tie, the thread not served by
// the previous grant wins. A lone request is served at once.
// Assumes the caller holds req stable within a cycle.
module sua_rr_pick
    import sua_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] req,
    input  logic               idle,
    output logic [NUM_THR-1:0] gnt
);
    tid_t last_q;

    // Purpose: choose the winner for this cycle.
    always_comb begin
        gnt = '0;
        if (idle) begin
            if (&req) begin
                gnt = last_q ? 2'b01 : 2'b10;
            end else begin
                gnt = req;
            end
        end
    end

    // Purpose: remember which thread was served last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else if (|gnt) begin
            last_q <= gnt[1];
        end
    end

    // R5: never more than one winner
    p_onehot_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9: a tied grant goes to the other thread than the grant before it
    p_tie_alternates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (&req) && gnt[1]) |=> (last_q == 1'b1));
endmodule

// File: rtl/sua_busy_timer.sv
// Occupancy countdown for the shared unit.
// On start it loads LATENCY and counts down by one each cycle. The unit
// counts as busy while the count is non-zero. Done is raised in the last
// busy cycle, tagged with the owning thread.
// Assumes start is only raised while the count is zero.
module sua_busy_timer
    import sua_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  tid_t start_tid,
    output logic busy,
    output logic done,
    output tid_t done_tid
);
    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LATENCY);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    tid_t             owner_q;

    // Purpose: load on start, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE_V;
        end
    end

    // Purpose: capture which thread owns the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
        end else if (start) begin
            owner_q <= start_tid;
        end
    end

    assign busy     = (cnt_q != '0);
    assign done     = (cnt_q == ONE_V);
    assign done_tid = owner_q;

    // R4: count stays within the latency
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_V);

    // R4: a start leads to a full count next cycle
    p_load_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == LOAD_V));

    // R8: done is followed by an idle unit
    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/shared_unit_arbiter.sv
// Top: occupancy tracking and fair grant for one non-pipelined unit
// shared by two threads. Grants combinationally in an idle cycle, then
// refuses all requests for LATENCY cycles. Stalls refused requesters.
// Assumes LATENCY >= 1.
module shared_unit_arbiter
    import sua_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    output logic [1:0] grant_o,
    output logic [1:0] stall_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       done_tid_o
);
    logic [NUM_THR-1:0] gnt;
    logic               busy;
    logic               done;
    tid_t               done_tid;

    sua_rr_pick u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_i),
        .idle (!busy),
        .gnt  (gnt)
    );

    sua_busy_timer #(.LATENCY(LATENCY)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (|gnt),
        .start_tid(gnt[1]),
        .busy     (busy),
        .done     (done),
        .done_tid (done_tid)
    );

    assign grant_o    = gnt;
    assign stall_o    = req_i & ~gnt;
    assign busy_o     = busy;
    assign done_o     = done;
    assign done_tid_o = done_tid;

    // R3: grants only when the timer reports idle
    p_grant_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> !busy_o);

    // R2: an idle unit serves any request
    p_idle_serves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (|req_i)) |-> (|grant_o));

    // R4: a grant makes the unit busy next cycle
    p_busy_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |=> busy_o);

    // R7: in a tie exactly one thread stalls
    p_tie_one_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&req_i) && (|grant_o)) |-> ($countones(stall_o) == 1));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/tb_shared_unit_arbiter.sv
module tb_shared_unit_arbiter;
    localparam int LAT = 3;
    localparam int NV  = 22;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] req_i;
    logic [1:0] grant_o;
    logic [1:0] stall_o;
    logic       busy_o;
    logic       done_o;
    logic       done_tid_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    shared_unit_arbiter #(.LATENCY(LAT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .grant_o   (grant_o),
        .stall_o   (stall_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .done_tid_o(done_tid_o)
    );

    // vector: {req[1:0], gnt[1:0], busy, done, done_tid}
    localparam logic [6:0] VEC [NV] = '{
        7'b00_00_0_0_0, // c0  R10 no request
        7'b01_01_0_0_0, // c1  R2 lone thread0
        7'b10_00_1_0_0, // c2  R3
        7'b11_00_1_0_0, // c3  R3
        7'b11_00_1_1_0, // c4  R8 done thread0
        7'b11_10_0_0_0, // c5  R6 tie -> thread1
        7'b11_00_1_0_0, // c6
        7'b11_00_1_0_0, // c7
        7'b11_00_1_1_1, // c8  R8 done thread1
        7'b11_01_0_0_0, // c9  R9 tie -> thread0
        7'b00_00_1_0_0, // c10
        7'b00_00_1_0_0, // c11
        7'b00_00_1_1_0, // c12
        7'b10_10_0_0_0, // c13 R2 lone thread1
        7'b00_00_1_0_0, // c14
        7'b00_00_1_0_0, // c15
        7'b00_00_1_1_1, // c16
        7'b10_10_0_0_0, // c17 R2 repeat thread1
        7'b00_00_1_0_0, // c18
        7'b00_00_1_0_0, // c19
        7'b00_00_1_1_1, // c20
        7'b11_01_0_0_0  // c21 R6 tie after thread1 -> thread0
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_i = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy in reset", int'(busy_o), 0);
        chk("R1 grant in reset", int'(grant_o), 0);
        chk("R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy_o), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_i = VEC[i][6:5];
            #1;
            chk($sformatf("R2/R3/R6 grant c%0d", i), int'(grant_o), int'(VEC[i][4:3]));
            chk($sformatf("R7 stall c%0d", i), int'(stall_o),
                int'(VEC[i][6:5] & ~VEC[i][4:3]));
            chk($sformatf("R4 busy c%0d", i), int'(busy_o), int'(VEC[i][2]));
            chk($sformatf("R8 done c%0d", i), int'(done_o), int'(VEC[i][1]));
            if (VEC[i][1])
                chk($sformatf("R8 done_tid c%0d", i), int'(done_tid_o), int'(VEC[i][0]));
        end

        // reset in the middle of an operation
        @(negedge clk);
        req_i = 2'b00;
        #1;
        chk("R4 busy before mid reset", int'(busy_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy after mid reset", int'(busy_o), 0);
        chk("R1 done after mid reset", int'(done_o), 0);
        rst_n = 1'b1;

        // tie right after reset: thread 0 first, then alternation
        begin
            int last_tid;
            int last_cyc;
            int ngr;
            last_tid = -1;
            last_cyc = -1;
            ngr = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                req_i = 2'b11;
                #1;
                if (grant_o != 2'b00) begin
                    if (ngr == 0) begin
                        chk("R6 first tie after reset", int'(grant_o), 1);
                    end else begin
                        chk("R9 alternation", int'(grant_o[1]), 1 - last_tid);
                        chk("R4 grant spacing", c - last_cyc, LAT + 1);
                    end
                    last_tid = int'(grant_o[1]);
                    last_cyc = c;
                    ngr++;
                end
            end
            chk("R9 grant count", ngr, 15);
        end

        @(negedge clk);
        req_i = 2'b00;
        repeat (LAT + 1) @(negedge clk);
        #1;
        chk("R10 idle with no request", int'(busy_o), 0);
        chk("R10 no grant", int'(grant_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule